// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block sits on the controller side of a DDR SDRAM interface. It decides when an auto-refresh is owed and asks the command arbiter for a slot. A free-running interval counter records one owed refresh each time it expires. The reload value comes from a 2-bit case-temperature band: the base average interval in the coolest band, half of it in the next band, and a quarter of it in the two hottest codes. Owed refreshes build up in a saturating debt counter. Whenever the arbiter can give slots, they are paid back one after another.

A refresh needs every bank closed. While debt is owed and the arbiter reports open banks, the block asks for a precharge-all instead of a refresh. After each granted command, a blackout counter holds `busy` high until the next command is legal: the row precharge time after a precharge-all, and the refresh row cycle time after a refresh. A pulse on `sr_exit` marks the cycle in which self-refresh was left. That pulse holds off non-read commands through `busy` for the exit time, and holds off reads through `rd_block` for a fixed number of cycles. All times are given in picoseconds and turned into cycle counts when the block is elaborated. Minimum times are rounded up, and the refresh interval is rounded down.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `ref_req`, `pre_all_req`, `busy` and `rd_block` are all 0.
- R2: The interval length in cycles is IV = floor(TREFI_PS/CLK_PS) for `temp_band` 0, IV/2 for band 1, and IV/4 for bands 2 and 3. The first refresh is owed IV(band) cycles after reset is released. With no backlog, the next one is owed IV(band) cycles after that.
- R3: A change of `temp_band` does not shorten the count already running. The new interval applies from the next reload.
- R4: While debt is owed and `busy` is 0, `ref_req` follows `banks_idle` and `pre_all_req` follows its inverse. The two requests are never high together, for any pattern of `banks_idle` and `grant`.
- R5: A precharge-all is issued when `grant` is high while `pre_all_req` is high. It leaves the debt unchanged. No request may be granted again until ceil(TRP_PS/CLK_PS) cycles after the grant.
- R6: A refresh is issued when `grant` is high while `ref_req` is high. It removes one unit of debt. Back-to-back refreshes are granted exactly ceil(TRFC_PS/CLK_PS) cycles apart.
- R7: The debt saturates at MAX_DEBT. Intervals that expire while the debt is full are lost.
- R8: When `sr_exit` is high at a clock edge, `busy` stays high until ceil(TXSNR_PS/CLK_PS) cycles later, and `rd_block` stays high until TXSRD_CYC cycles later.
- R9: `grant` has no effect while neither request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_band | input | 2 | Case-temperature band, 0 coolest |
| banks_idle | input | 1 | All banks are closed |
| grant | input | 1 | Arbiter accepts the request that is high this cycle |
| sr_exit | input | 1 | One-cycle pulse: self-refresh was exited this cycle |
| ref_req | output | 1 | Auto-refresh request |
| pre_all_req | output | 1 | Precharge-all request, needed before a refresh |
| busy | output | 1 | Blackout: no command may be issued |
| rd_block | output | 1 | Read blackout after self-refresh exit |

## Verification
The assertions assume that `grant` is honoured in the same cycle it is sampled and refers only to the request high in that cycle. They also assume that `sr_exit` comes as an isolated one-cycle pulse, and that both blackout times span at least two cycles. The stimulus drives every input on the falling edge. In the random phase it draws `banks_idle` and `grant` freely but holds `temp_band` fixed and `sr_exit` low. It then drains the backlog, so that the total number of refreshes can be predicted from the elapsed cycles alone.

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched #(
  parameter int CLK_PS    = 5000,
  parameter int TREFI_PS  = 7_800_000,
  parameter int TRFC_PS   = 70_000,
  parameter int TRP_PS    = 15_000,
  parameter int TXSNR_PS  = 75_000,
  parameter int TXSRD_CYC = 200,
  parameter int MAX_DEBT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] temp_band,
  input  logic       banks_idle,
  input  logic       grant,
  input  logic       sr_exit,
  output logic       ref_req,
  output logic       pre_all_req,
  output logic       busy,
  output logic       rd_block
);
  localparam int IVAL    = TREFI_PS / CLK_PS;
  localparam int TRFC_C  = (TRFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP_C   = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TXSNR_C = (TXSNR_PS + CLK_PS - 1) / CLK_PS;
  localparam int BMAX1   = TRFC_C > TRP_C ? TRFC_C : TRP_C;
  localparam int BMAX    = BMAX1 > TXSNR_C ? BMAX1 : TXSNR_C;
  localparam int IW      = $clog2(IVAL + 1);
  localparam int DW      = $clog2(MAX_DEBT + 1);
  localparam int BW      = $clog2(BMAX + 1);
  localparam int RW      = $clog2(TXSRD_CYC + 1);

  localparam logic [IW-1:0] IV0    = IW'(IVAL);
  localparam logic [IW-1:0] IV1    = IW'(IVAL / 2);
  localparam logic [IW-1:0] IV2    = IW'(IVAL / 4);
  localparam logic [BW-1:0] RFC_L  = BW'(TRFC_C > 0 ? TRFC_C - 1 : 0);
  localparam logic [BW-1:0] RP_L   = BW'(TRP_C > 0 ? TRP_C - 1 : 0);
  localparam logic [BW-1:0] XSNR_L = BW'(TXSNR_C > 0 ? TXSNR_C - 1 : 0);
  localparam logic [RW-1:0] RD_L   = RW'(TXSRD_CYC > 0 ? TXSRD_CYC - 1 : 0);
  localparam logic [DW-1:0] DMAX   = DW'(MAX_DEBT);

  logic [IW-1:0] tcnt, ival_sel;
  logic [DW-1:0] debt;
  logic [BW-1:0] blk, blk_nxt;
  logic [RW-1:0] rd_cnt;
  logic          tick, inc, dec, owed;

  always_comb
    case (temp_band)
      2'd0:    ival_sel = IV0;
      2'd1:    ival_sel = IV1;
      default: ival_sel = IV2;
    endcase

  assign tick        = (tcnt == '0);
  assign owed        = (debt != '0) && !busy;
  assign ref_req     = owed && banks_idle;
  assign pre_all_req = owed && !banks_idle;
  assign busy        = (blk != '0);
  assign rd_block    = (rd_cnt != '0);
  assign inc         = tick && (debt != DMAX);
  assign dec         = ref_req && grant;

  always_ff @(posedge clk)
    if (!rst_n)    tcnt <= ival_sel - 1'b1;
    else if (tick) tcnt <= ival_sel - 1'b1;
    else           tcnt <= tcnt - 1'b1;

  always_ff @(posedge clk)
    if (!rst_n)          debt <= '0;
    else if (inc && !dec) debt <= debt + 1'b1;
    else if (dec && !inc) debt <= debt - 1'b1;

  always_comb begin
    blk_nxt = busy ? blk - 1'b1 : '0;
    if (ref_req && grant)          blk_nxt = RFC_L;
    else if (pre_all_req && grant) blk_nxt = RP_L;
    if (sr_exit && blk_nxt < XSNR_L) blk_nxt = XSNR_L;
  end

  always_ff @(posedge clk)
    if (!rst_n) blk <= '0;
    else        blk <= blk_nxt;

  always_ff @(posedge clk)
    if (!rst_n)        rd_cnt <= '0;
    else if (sr_exit)  rd_cnt <= RD_L;
    else if (rd_block) rd_cnt <= rd_cnt - 1'b1;
endmodule

module refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic grant,
  input logic sr_exit,
  input logic ref_req,
  input logic pre_all_req,
  input logic busy,
  input logic rd_block
);
  // R4
  excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && pre_all_req));
  // R4
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> banks_idle);
  // R6
  rfc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && grant) |=> (busy && !ref_req && !pre_all_req));
  // R5
  rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_req && grant) |=> (busy && !ref_req && !pre_all_req));
  // R8
  srx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> (rd_block && busy));
  // R9
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !ref_req && !pre_all_req && !busy && !sr_exit) |=> !busy);
endmodule

bind refresh_sched refresh_sched_chk chk_i (.*);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  localparam int TCK      = 10;
  localparam int CLK_PS   = 6000;
  localparam int TREFI_PS = 720_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] temp_band = 2'd0;
  logic banks_idle = 1'b1, grant = 1'b0, sr_exit = 1'b0;
  logic ref_req, pre_all_req, busy, rd_block;
  int cyc = 0, checks = 0, fails = 0;

  refresh_sched #(.CLK_PS(CLK_PS), .TREFI_PS(TREFI_PS)) uut (
    .clk(clk), .rst_n(rst_n), .temp_band(temp_band), .banks_idle(banks_idle),
    .grant(grant), .sr_exit(sr_exit), .ref_req(ref_req),
    .pre_all_req(pre_all_req), .busy(busy), .rd_block(rd_block));

  always #(TCK/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic int ceil_cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int exp_ival(input int b);
    int base = TREFI_PS / CLK_PS;
    return b == 0 ? base : (b == 1 ? base / 2 : base / 4);
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input int b);
    temp_band = 2'(b); banks_idle = 1'b1; grant = 1'b0; sr_exit = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(output int c);
    c = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (ref_req || pre_all_req) begin c = cyc; break; end
    end
  endtask

  task automatic grant_one();
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    summary();
  end

  initial begin
    int c, c2, n, nb, nr, refs, last, bad;
    int unsigned s;
    s = $urandom(32'd4242);

    // R1 reset state
    temp_band = 2'd0; rst_n = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk("R1 during reset", {ref_req, pre_all_req, busy, rd_block}, 0);
    rst_n = 1'b1; #1;
    chk("R1 after reset", {ref_req, pre_all_req, busy, rd_block}, 0);

    // R2 interval per band
    for (int b = 0; b < 4; b++) begin
      do_reset(b);
      wait_req(c);
      chk($sformatf("R2 first owed band %0d", b), c, exp_ival(b));
      grant_one();
      wait_req(c2);
      chk($sformatf("R2 second owed band %0d", b), c2, 2 * exp_ival(b));
    end

    // R3 band change applies at reload
    do_reset(0);
    repeat (50) @(negedge clk);
    temp_band = 2'd2;
    wait_req(c);
    chk("R3 running count kept", c, exp_ival(0));
    grant_one();
    wait_req(c2);
    chk("R3 new interval after reload", c2, exp_ival(0) + exp_ival(2));

    // R4 / R5 precharge first when banks open
    do_reset(2);
    banks_idle = 1'b0;
    wait_req(c);
    chk("R4 pre_all when open", {ref_req, pre_all_req}, 2'b01);
    grant = 1'b1; n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); grant = 1'b0; n++; #1;
      if (ref_req || pre_all_req) break;
    end
    chk("R5 precharge blackout", n, ceil_cyc(15_000));
    banks_idle = 1'b1; #1;
    chk("R4 ref when idle", {ref_req, pre_all_req}, 2'b10);

    // R6 refresh blackout and debt decrement
    grant = 1'b1; n = 0; nb = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); grant = 1'b0; n++; #1;
      if (!busy && nb < 0) nb = n;
    end
    chk("R6 refresh blackout", nb, ceil_cyc(70_000));
    chk("R6 debt cleared", {ref_req, pre_all_req}, 0);

    // R6 back-to-back spacing
    do_reset(2);
    while (cyc < 95) @(negedge clk);
    grant = 1'b1; refs = 0; last = -1;
    while (cyc <= 119) begin
      #1;
      if (ref_req) begin
        if (last >= 0) chk("R6 back-to-back spacing", cyc - last, ceil_cyc(70_000));
        last = cyc; refs++;
      end
      @(negedge clk);
    end
    grant = 1'b0;
    chk("R6 backlog of three paid", refs, 3);

    // R7 saturation
    do_reset(0);
    while (cyc < 1090) @(negedge clk);
    grant = 1'b1; refs = 0;
    while (cyc <= 1195) begin
      #1; if (ref_req) refs++;
      @(negedge clk);
    end
    grant = 1'b0;
    chk("R7 debt saturates", refs, 8);

    // R8 self-refresh exit windows
    do_reset(0);
    repeat (5) @(negedge clk);
    sr_exit = 1'b1;
    @(negedge clk); sr_exit = 1'b0; #1;
    chk("R8 read hold set", rd_block, 1);
    n = 1; nb = -1; nr = -1;
    while (n < 260) begin
      #1;
      if (!busy && nb < 0) nb = n;
      if (!rd_block && nr < 0) nr = n;
      @(negedge clk); n++;
    end
    chk("R8 non-read hold", nb, ceil_cyc(75_000));
    chk("R8 read hold", nr, 200);

    // R9 grant without request
    do_reset(0);
    repeat (5) @(negedge clk);
    grant = 1'b1;
    @(negedge clk); #1;
    chk("R9 stray grant no busy", busy, 0);
    grant = 1'b0;
    wait_req(c);
    chk("R9 interval unaffected", c, exp_ival(0));

    // R4 / R6 random grants and bank state
    do_reset(1);
    refs = 0; bad = 0;
    while (cyc < 2200) begin
      @(negedge clk);
      banks_idle = 1'($urandom % 2);
      grant = ($urandom % 3) != 0;
      #1;
      if (ref_req && pre_all_req) bad++;
      if (ref_req && !banks_idle) bad++;
      if (ref_req && grant) refs++;
    end
    banks_idle = 1'b1; grant = 1'b1;
    while (cyc < 2399) begin
      @(negedge clk); #1;
      if (ref_req) refs++;
    end
    grant = 1'b0;
    chk("R4 random request exclusivity", bad, 0);
    chk("R6 random total refreshes", refs, 2399 / exp_ival(1));

    summary();
  end
endmodule